// File: doc/BRIEF.md
# Grouped Input Capture Bank Pair

This block sits between a device's input pins and its logic array. It holds two banks of capture cells: one for the dedicated input pins and one for the bidirectional pins. Each bank has its own two-bit mode setting. When the sync bit is clear, the bank passes its pins straight through. When the sync bit is set, the latch bit chooses the capture style. With the latch bit set, the bank is a transparent latch that is open while the shared capture clock pin is high. With the latch bit clear, the bank is a register that takes the pins on a rising capture clock. The mode always applies to a whole bank, never to single cells.

The capture clock pin is sampled by the system clock `clk`. Latch transparency is combinational, so the output follows the pins as soon as the capture clock is high. The stored value is written at each `clk` edge while the latch is open. A rising capture clock is detected against its value at the previous `clk` edge. For test, each bank has a preload strobe that forces its stored word to an arbitrary value, so that the logic downstream can be started from any captured state.

Top module: `incap_bank_pair`

## Requirements
- R1: With its sync bit at 0, a bank's output equals its pins in the same cycle, whatever its latch bit and the capture clock are.
- R2: With sync=1 and latch=1, while `cap_clk` is 1 the bank's output equals its pins in the same cycle.
- R3: With sync=1 and latch=1, after `cap_clk` falls the output keeps the pin value seen at the last `clk` edge at which `cap_clk` was 1, and later pin changes have no effect.
- R4: With sync=1 and latch=0, the stored word takes the pins at the first `clk` edge that sees `cap_clk`=1 after an edge that saw it at 0. The output shows the stored word and does not change while `cap_clk` stays high or low.
- R5: A preload strobe loads the bank's preload data into its stored word at the `clk` edge. When preload and capture fall on the same edge, preload wins.
- R6: The two banks are independent. One bank's mode bits, pins and preload strobe have no effect on the other bank's output.
- R7: Reset (rst_n=0, asynchronous) clears both stored words and the capture clock history to 0. In register mode each output then reads 0.
- R8: In pass-through mode the stored word changes only by preload. After a switch to register mode with no capture, the output shows the word held before the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_clk | input | 1 | Shared capture clock / latch enable pin |
| in_syn | input | 1 | Dedicated bank: 1 = capture, 0 = pass-through |
| in_latch | input | 1 | Dedicated bank: 1 = latch, 0 = register (when in_syn=1) |
| io_syn | input | 1 | Bidirectional bank: 1 = capture, 0 = pass-through |
| io_latch | input | 1 | Bidirectional bank: 1 = latch, 0 = register (when io_syn=1) |
| in_pins | input | N_IN | Dedicated input pin values |
| io_pins | input | N_IO | Bidirectional pin values |
| pl_in_stb | input | 1 | Preload strobe, dedicated bank |
| pl_in_data | input | N_IN | Preload value, dedicated bank |
| pl_io_stb | input | 1 | Preload strobe, bidirectional bank |
| pl_io_data | input | N_IO | Preload value, bidirectional bank |
| in_cap | output | N_IN | Captured view of the dedicated bank |
| io_cap | output | N_IO | Captured view of the bidirectional bank |

## Verification
The bench holds the capture clock high across several `clk` edges in register mode. A design that captured on the level instead of the edge would follow the pins there. It also drops the clock in latch mode and then moves the pins, which catches a latch that stays open or loses its value. A preload is placed on the same edge as a rising capture clock, so a design with the wrong priority shows the pin word instead of the preload word. Finally, one bank is preloaded and reconfigured while the other is watched, which exposes shared state or crossed mode bits between the banks.

// File: rtl/incap_pkg.sv
package incap_pkg;

  typedef enum logic [1:0] {
    CAP_DIRECT = 2'd0,
    CAP_LATCH  = 2'd1,
    CAP_EDGE   = 2'd2
  } cap_mode_e;

  // Sync bit off means pass-through regardless of the latch bit.
  function automatic cap_mode_e decode_mode(input logic syn, input logic latch);
    if (!syn)  return CAP_DIRECT;
    if (latch) return CAP_LATCH;
    return CAP_EDGE;
  endfunction

  // Whether the stored word should take the pins at this clk edge.
  function automatic logic take_sample(input cap_mode_e m, input logic cap_hi,
                                       input logic cap_rise);
    logic r;
    unique case (m)
      CAP_LATCH: r = cap_hi;
      CAP_EDGE:  r = cap_rise;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

  // Whether the output shows the live pins instead of the stored word.
  function automatic logic show_pins(input cap_mode_e m, input logic cap_hi);
    return (m == CAP_DIRECT) || ((m == CAP_LATCH) && cap_hi);
  endfunction

endpackage

// File: rtl/incap_clk_sense.sv
module incap_clk_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_clk,
  output logic cap_hi,
  output logic cap_rise
);
  logic cap_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_prev_q <= 1'b0;
    else        cap_prev_q <= cap_clk;
  end

  assign cap_hi   = cap_clk;
  assign cap_rise = cap_clk & ~cap_prev_q;

  // A rise can never be reported on two edges in a row.
  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_rise |=> !cap_rise); // R4

endmodule

// File: rtl/incap_bank.sv
module incap_bank
  import incap_pkg::*;
#(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_syn,
  input  logic             cfg_latch,
  input  logic             cap_hi,
  input  logic             cap_rise,
  input  logic             pl_stb,
  input  logic [WIDTH-1:0] pl_data,
  input  logic [WIDTH-1:0] pins,
  output logic [WIDTH-1:0] view
);
  localparam int LAST = WIDTH - 1;

  cap_mode_e        mode;
  logic             sample_en;
  logic             live_sel;
  logic [LAST:0]    held_q;

  assign mode      = decode_mode(cfg_syn, cfg_latch);
  assign sample_en = take_sample(mode, cap_hi, cap_rise);
  assign live_sel  = show_pins(mode, cap_hi);

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         held_q[g] <= 1'b0;
        else if (pl_stb)    held_q[g] <= pl_data[g];
        else if (sample_en) held_q[g] <= pins[g];
      end
      assign view[g] = live_sel ? pins[g] : held_q[g];
    end
  endgenerate

  AST_DIRECT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_syn) |-> (view == pins)); // R1

  AST_LATCH_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_syn && cfg_latch && cap_hi) |-> (view == pins)); // R2

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_syn && cfg_latch && !cap_hi && !pl_stb) |=> $stable(held_q)); // R3

  AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_syn && !cfg_latch && cap_rise && !pl_stb) |=> (held_q == $past(pins))); // R4

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_syn && !cfg_latch && !cap_rise && !pl_stb) |=> $stable(held_q)); // R4

  AST_PRELOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    pl_stb |=> (held_q == $past(pl_data))); // R5

  AST_DIRECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_syn && !pl_stb) |=> $stable(held_q)); // R8

endmodule

// File: rtl/incap_bank_pair.sv
module incap_bank_pair #(
  parameter int N_IN = 10,
  parameter int N_IO = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_clk,
  input  logic            in_syn,
  input  logic            in_latch,
  input  logic            io_syn,
  input  logic            io_latch,
  input  logic [N_IN-1:0] in_pins,
  input  logic [N_IO-1:0] io_pins,
  input  logic            pl_in_stb,
  input  logic [N_IN-1:0] pl_in_data,
  input  logic            pl_io_stb,
  input  logic [N_IO-1:0] pl_io_data,
  output logic [N_IN-1:0] in_cap,
  output logic [N_IO-1:0] io_cap
);
  logic cap_hi;
  logic cap_rise;

  incap_clk_sense u_sense (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_clk  (cap_clk),
    .cap_hi   (cap_hi),
    .cap_rise (cap_rise)
  );

  incap_bank #(.WIDTH(N_IN)) u_in_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_syn   (in_syn),
    .cfg_latch (in_latch),
    .cap_hi    (cap_hi),
    .cap_rise  (cap_rise),
    .pl_stb    (pl_in_stb),
    .pl_data   (pl_in_data),
    .pins      (in_pins),
    .view      (in_cap)
  );

  incap_bank #(.WIDTH(N_IO)) u_io_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_syn   (io_syn),
    .cfg_latch (io_latch),
    .cap_hi    (cap_hi),
    .cap_rise  (cap_rise),
    .pl_stb    (pl_io_stb),
    .pl_data   (pl_io_data),
    .pins      (io_pins),
    .view      (io_cap)
  );

  // Register-mode dedicated bank reads zero right after reset.
  AST_RESET_CLEAR: assert property (@(posedge clk)
    (!rst_n && in_syn && !in_latch) |-> (in_cap == '0)); // R7

endmodule

// File: tb/incap_bank_pair_tb.sv
module incap_bank_pair_tb;
  localparam int W = 10;
  localparam int NV = 15;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cap_clk = 1'b0;
  logic         in_syn = 1'b1, in_latch = 1'b0, io_syn = 1'b1, io_latch = 1'b0;
  logic [W-1:0] in_pins = '0, io_pins = '0;
  logic         pl_in_stb = 1'b0, pl_io_stb = 1'b0;
  logic [W-1:0] pl_in_data = '0, pl_io_data = '0;
  logic [W-1:0] in_cap, io_cap;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  incap_bank_pair #(.N_IN(W), .N_IO(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cap_clk(cap_clk),
    .in_syn(in_syn), .in_latch(in_latch), .io_syn(io_syn), .io_latch(io_latch),
    .in_pins(in_pins), .io_pins(io_pins),
    .pl_in_stb(pl_in_stb), .pl_in_data(pl_in_data),
    .pl_io_stb(pl_io_stb), .pl_io_data(pl_io_data),
    .in_cap(in_cap), .io_cap(io_cap)
  );

  // {syn, latch, cap_clk, preload, preload data, pins, expected in_cap}
  localparam logic [33:0] VEC [NV] = '{
    {4'b0000, 10'h000, 10'h155, 10'h155}, // R1 pass-through
    {4'b0010, 10'h000, 10'h0AA, 10'h0AA}, // R1 capture clock ignored
    {4'b1010, 10'h000, 10'h3FF, 10'h000}, // R4 high level, no rise
    {4'b1000, 10'h000, 10'h123, 10'h000}, // R4 low
    {4'b1010, 10'h000, 10'h123, 10'h123}, // R4 rise captures
    {4'b1010, 10'h000, 10'h0F0, 10'h123}, // R4 hold while high
    {4'b1000, 10'h000, 10'h0F0, 10'h123}, // R4 hold while low
    {4'b1011, 10'h2A5, 10'h111, 10'h2A5}, // R5 preload beats rise
    {4'b1110, 10'h000, 10'h0C3, 10'h0C3}, // R2 transparent
    {4'b1110, 10'h000, 10'h1E1, 10'h1E1}, // R2 follows pins
    {4'b1100, 10'h000, 10'h000, 10'h1E1}, // R3 holds after fall
    {4'b1100, 10'h000, 10'h3C3, 10'h1E1}, // R3 pins ignored
    {4'b1101, 10'h05A, 10'h3C3, 10'h05A}, // R5 preload while closed
    {4'b0100, 10'h000, 10'h2DB, 10'h2DB}, // R1 sync off beats latch bit
    {4'b1000, 10'h000, 10'h000, 10'h05A}  // R8 word kept through pass-through
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset in bank", in_cap, '0);
    check("R7 reset io bank", io_cap, '0);
    @(negedge clk);
    rst_n = 1'b1;
    io_syn = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {in_syn, in_latch, cap_clk, pl_in_stb} = VEC[i][33:30];
      pl_in_data = VEC[i][29:20];
      in_pins    = VEC[i][19:10];
      @(posedge clk);
      #1;
      check($sformatf("vector %0d (R1-R5,R8 table)", i), in_cap, VEC[i][9:0]);
    end

    // R6: banks in different modes on one rising capture clock
    @(negedge clk);
    pl_in_stb = 1'b0;
    in_syn = 1'b1; in_latch = 1'b0;
    io_syn = 1'b0;
    in_pins = 10'h2B4; io_pins = 10'h0F3;
    cap_clk = 1'b1;
    @(posedge clk); #1;
    check("R6 in bank edge capture", in_cap, 10'h2B4);
    check("R6 io bank pass-through", io_cap, 10'h0F3);

    // R6 and R5: preload io bank only, in bank must not move
    @(negedge clk);
    io_syn = 1'b1; io_latch = 1'b0;
    pl_io_stb = 1'b1; pl_io_data = 10'h199;
    in_pins = 10'h001;
    @(posedge clk); #1;
    check("R5 io preload", io_cap, 10'h199);
    check("R6 in bank untouched", in_cap, 10'h2B4);

    // R7: asynchronous reset in mid-run
    @(negedge clk);
    pl_io_stb = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R7 mid-run in bank", in_cap, '0);
    check("R7 mid-run io bank", io_cap, '0);
    @(negedge clk);
    rst_n = 1'b1;
    cap_clk = 1'b0;
    @(posedge clk); #1;

    done = 1'b1;
    finish_run();
  end

endmodule